// File: doc/BRIEF.md
# Low-Toggle Multi-Chain Test Pattern Generator

This block produces low-switching test stimulus for built-in self-test. A slow seed register, built as a maximal-length linear feedback shift register, is combined by a grid of two-input XOR gates with a fast Johnson counter. Each output column follows one seed bit, and each output row follows one Johnson stage. While a seed is held, each new pattern changes one Johnson stage, so every column sees exactly one changing bit per step. The result is a set of single-input-change sequences that all carry the same seed bias.

Both rates come from one clock through internal enable strobes. A small controller runs one of two procedures. The first applies a new Johnson vector on every clock. The second models scan loading: one Johnson step, then a full circular rotation of the counter, then one capture strobe. A pulse on `start` samples the scheme and the seed budget. The run clears the counter, reloads the seed and runs until the budget of seeds is used up. It then raises `done`.

Top module: `lowtoggle_tpg`

## Requirements
- R1: While reset is low and after it is released, the seed holds 0x01, every Johnson stage is 0, and `capture` and `done` are 0. Every row of `pattern` is therefore 0x01.
- R2: One seed advance shifts the seed left by one place. The new bit 0 is the XOR of seed bits 7, 5, 4 and 3, which gives the polynomial x^8+x^6+x^5+x^4+1. The seed changes at no other time except a reload.
- R3: Pattern bit `r*SEED_W + c` equals seed bit c XOR Johnson stage r, for every row r and column c.
- R4: A Johnson step shifts the stages up by one and moves the inverse of the top stage into stage 0. From all zeros, step n (n below JOHN_LEN) sets stages 0..n-1. Later steps clear stages from the bottom, so the counter returns to zero after 2*JOHN_LEN steps.
- R5: The start edge is followed by JOHN_LEN clear cycles. These shift zeros into the counter and reload the seed. When `scanSel` was 0 at start, every following cycle makes one Johnson step. The seed advances on the same edge as every 2*JOHN_LEN-th step.
- R6: In the per-clock scheme, any two consecutive patterns inside one seed period differ in exactly one row of each column.
- R7: When `scanSel` was 1 at start, each Johnson vector uses 2+JOHN_LEN cycles: one step, then JOHN_LEN one-place circular rotations, then one capture cycle. The seed advances at the end of the capture cycle that completes 2*JOHN_LEN vectors.
- R8: `capture` is high for exactly the one capture cycle of each vector in the scan scheme. It is never high in the per-clock scheme.
- R9: After `patLimit` seeds have each run a full 2*JOHN_LEN vectors, `done` rises. The pattern then stays frozen until the next `start`.
- R10: A `patLimit` of 0 raises `done` directly after the clear cycles, and no Johnson step occurs.
- R11: `scanSel` and `patLimit` are sampled only on the start edge. A `start` pulse during a run has no effect.
- R12: A new start after a finished run reloads the seed to 0x01 before any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both update rates |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or finished |
| scanSel | input | 1 | 0 selects the per-clock scheme, 1 selects the scan scheme |
| patLimit | input | LIM_W | Number of seeds to use in the run |
| pattern | output | JOHN_LEN*SEED_W | XOR grid output, row-major by Johnson stage |
| capture | output | 1 | One-cycle capture strobe in the scan scheme |
| done | output | 1 | High once the seed budget is used up |

## Verification
The bench targets the seed boundary. A seed advance placed one step early or late would break the single-change property and shift every later pattern. It checks the rotation phase of the scan scheme: a rotation that does not wrap the top stage would corrupt the vector before capture and drop the stage weight. It also drives a zero seed budget, where an off-by-one end test would run a full period or never finish. Finally it pokes `start` in the middle of a scan run, which a design that re-samples its controls would turn into a per-clock run with a different count of captures.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CLK,
    ST_SSTEP,
    ST_SSHIFT,
    ST_SCAP,
    ST_DONE
  } ltpgState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic seedLoad;   // reload the seed to its initial value
    logic seedAdv;    // one seed register step
    logic johnEn;     // Johnson counter updates this cycle
    logic johnMode;   // 0: Johnson step, 1: shift register
    logic johnInit;   // with johnMode=1: 0 shifts zeros in, 1 rotates
  } ltpgCtl_s;

endpackage

// File: rtl/ltpg_datapath.sv
module ltpg_datapath
  import ltpg_pkg::*;
#(
  parameter int SEED_W = 8,
  parameter int JOHN_LEN = 4,
  parameter logic [SEED_W-1:0] SEED_TAPS = 8'hB8,
  parameter logic [SEED_W-1:0] SEED_INIT = 8'h01
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ltpgCtl_s                   ctl,
  output logic [JOHN_LEN*SEED_W-1:0] pattern
);

  logic [SEED_W-1:0]   seed;
  logic [JOHN_LEN-1:0] john;

  // Slow seed register: Fibonacci LFSR
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             seed <= SEED_INIT;
    else if (ctl.seedLoad) seed <= SEED_INIT;
    else if (ctl.seedAdv)  seed <= {seed[SEED_W-2:0], ^(seed & SEED_TAPS)};
  end

  // Fast reconfigurable Johnson counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) john <= '0;
    else if (ctl.johnEn) begin
      if (!ctl.johnMode)     john <= {john[JOHN_LEN-2:0], ~john[JOHN_LEN-1]};
      else if (!ctl.johnInit) john <= {john[JOHN_LEN-2:0], 1'b0};
      else                   john <= {john[JOHN_LEN-2:0], john[JOHN_LEN-1]};
    end
  end

  // XOR grid: rows follow Johnson stages, columns follow seed bits
  for (genvar r = 0; r < JOHN_LEN; r++) begin : gRow
    for (genvar c = 0; c < SEED_W; c++) begin : gCol
      assign pattern[r*SEED_W + c] = seed[c] ^ john[r];
    end
  end

  a_r2_seed_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.seedLoad || ctl.seedAdv) |=> $stable(seed));

  a_r2_seed_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    seed != '0);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.johnEn && !ctl.johnMode) |=> $countones(john ^ $past(john)) == 1);

  a_r7_rotate_weight: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.johnEn && ctl.johnMode && ctl.johnInit) |=>
      $countones(john) == $countones($past(john)));

  a_r9_john_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.johnEn |=> $stable(john));

endmodule

// File: rtl/ltpg_ctrl.sv
module ltpg_ctrl
  import ltpg_pkg::*;
#(
  parameter int JOHN_LEN = 4,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             scanSel,
  input  logic [LIM_W-1:0] patLimit,
  output ltpgCtl_s         ctl,
  output logic             capture,
  output logic             done
);

  localparam int SH_W = $clog2(JOHN_LEN);
  localparam int VEC_W = $clog2(2*JOHN_LEN);
  localparam logic [SH_W-1:0] SH_LAST = SH_W'(JOHN_LEN-1);
  localparam logic [VEC_W-1:0] VEC_LAST = VEC_W'(2*JOHN_LEN-1);

  ltpgState_e       state;
  logic [SH_W-1:0]  shCnt;
  logic [VEC_W-1:0] vecCnt;
  logic [LIM_W-1:0] seedCnt;
  logic [LIM_W-1:0] limReg;
  logic             scanReg;
  logic             shLast, vecLast, seedLast;

  assign shLast   = (shCnt == SH_LAST);
  assign vecLast  = (vecCnt == VEC_LAST);
  assign seedLast = (({1'b0, seedCnt} + {{LIM_W{1'b0}}, 1'b1}) == {1'b0, limReg});

  always_comb begin
    ctl = '0;
    case (state)
      ST_LOAD:   begin ctl.seedLoad = 1'b1; ctl.johnEn = 1'b1; ctl.johnMode = 1'b1; end
      ST_CLK:    begin ctl.johnEn = 1'b1; ctl.seedAdv = vecLast; end
      ST_SSTEP:  ctl.johnEn = 1'b1;
      ST_SSHIFT: begin ctl.johnEn = 1'b1; ctl.johnMode = 1'b1; ctl.johnInit = 1'b1; end
      ST_SCAP:   ctl.seedAdv = vecLast;
      default:   ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      shCnt   <= '0;
      vecCnt  <= '0;
      seedCnt <= '0;
      limReg  <= '0;
      scanReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state   <= ST_LOAD;
          shCnt   <= '0;
          scanReg <= scanSel;
          limReg  <= patLimit;
        end
        ST_LOAD: if (shLast) begin
          shCnt   <= '0;
          vecCnt  <= '0;
          seedCnt <= '0;
          if (limReg == '0) state <= ST_DONE;
          else              state <= scanReg ? ST_SSTEP : ST_CLK;
        end else shCnt <= shCnt + 1'b1;
        ST_CLK: if (vecLast) begin
          vecCnt  <= '0;
          seedCnt <= seedCnt + 1'b1;
          if (seedLast) state <= ST_DONE;
        end else vecCnt <= vecCnt + 1'b1;
        ST_SSTEP: begin
          shCnt <= '0;
          state <= ST_SSHIFT;
        end
        ST_SSHIFT: if (shLast) state <= ST_SCAP;
                   else        shCnt <= shCnt + 1'b1;
        ST_SCAP: begin
          if (vecLast) begin
            vecCnt  <= '0;
            seedCnt <= seedCnt + 1'b1;
          end else vecCnt <= vecCnt + 1'b1;
          state <= (vecLast && seedLast) ? ST_DONE : ST_SSTEP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign capture = (state == ST_SCAP);
  assign done    = (state == ST_DONE);

  a_r8_capture_single: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !capture);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r11_limit_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_DONE) |=> ($stable(limReg) && $stable(scanReg)));

endmodule

// File: rtl/lowtoggle_tpg.sv
module lowtoggle_tpg
  import ltpg_pkg::*;
#(
  parameter int SEED_W = 8,
  parameter int JOHN_LEN = 4,
  parameter int LIM_W = 8,
  parameter logic [SEED_W-1:0] SEED_TAPS = 8'hB8,
  parameter logic [SEED_W-1:0] SEED_INIT = 8'h01
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       scanSel,
  input  logic [LIM_W-1:0]           patLimit,
  output logic [JOHN_LEN*SEED_W-1:0] pattern,
  output logic                       capture,
  output logic                       done
);

  ltpgCtl_s ctl;

  ltpg_ctrl #(
    .JOHN_LEN(JOHN_LEN),
    .LIM_W(LIM_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .scanSel(scanSel),
    .patLimit(patLimit),
    .ctl(ctl),
    .capture(capture),
    .done(done)
  );

  ltpg_datapath #(
    .SEED_W(SEED_W),
    .JOHN_LEN(JOHN_LEN),
    .SEED_TAPS(SEED_TAPS),
    .SEED_INIT(SEED_INIT)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .pattern(pattern)
  );

endmodule

// File: tb/lowtoggle_tpg_test.sv
module lowtoggle_tpg_test;

  localparam int M  = 8;
  localparam int L  = 4;
  localparam int LW = 8;
  localparam int PW = L*M;
  localparam int B  = L + 2;
  localparam logic [M-1:0] INIT = 8'h01;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic          scanSel;
  logic [LW-1:0] patLimit;
  logic [PW-1:0] pattern;
  logic          capture;
  logic          done;

  lowtoggle_tpg uut (
    .clk(clk), .rstN(rstN), .start(start), .scanSel(scanSel),
    .patLimit(patLimit), .pattern(pattern), .capture(capture), .done(done)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  bit           mRun, mDone, mScan, expCap, sicChk;
  int           mLim, t, capSeen;
  string        patTag;
  logic [M-1:0] expSeed;
  logic [L-1:0] expJohn;
  logic [PW-1:0] prevPat;

  function automatic logic [M-1:0] lfsrNext(input logic [M-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // Johnson state after n steps from zero
  function automatic logic [L-1:0] jv(input int n);
    logic [L-1:0] v;
    for (int i = 0; i < L; i++) v[i] = (n < L) ? (i < n) : (i >= n - L);
    return v;
  endfunction

  function automatic logic [L-1:0] rotl(input logic [L-1:0] v, input int p);
    logic [L-1:0] x = v;
    for (int k = 0; k < p; k++) x = {x[L-2:0], x[L-1]};
    return x;
  endfunction

  function automatic logic [PW-1:0] buildPat(input logic [M-1:0] s, input logic [L-1:0] j);
    logic [PW-1:0] q;
    for (int r = 0; r < L; r++)
      for (int c = 0; c < M; c++) q[r*M + c] = s[c] ^ j[r];
    return q;
  endfunction

  task automatic chkVec(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pattern act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    int s, b, p;
    expCap = 1'b0;
    sicChk = 1'b0;
    if (!mRun) begin
      if (start) begin
        mRun = 1'b1; t = 0; mScan = scanSel; mLim = int'(patLimit); mDone = 1'b0;
        patTag = "R12";
      end
    end else begin
      t++;
      if (t <= L) begin
        patTag = "R12";
        expSeed = INIT;
        expJohn = expJohn << 1;
        if (t == L && mLim == 0) begin mRun = 1'b0; mDone = 1'b1; end
      end else begin
        s = t - L;
        if (!mScan) begin
          patTag = "R3 R4 R5";
          expJohn = jv(s % (2*L));
          if (s % (2*L) == 0) expSeed = lfsrNext(expSeed);
          else sicChk = 1'b1;
          if (s == mLim*2*L) begin mRun = 1'b0; mDone = 1'b1; end
        end else begin
          patTag = "R3 R7";
          b = (s - 1) / B;
          p = (s - 1) % B;
          if (p <= L) expJohn = rotl(jv((b + 1) % (2*L)), p);
          if (p == L) expCap = 1'b1;
          if (p == L + 1) begin
            if ((b + 1) % (2*L) == 0) expSeed = lfsrNext(expSeed);
            if (b + 1 == mLim*2*L) begin mRun = 1'b0; mDone = 1'b1; end
          end
        end
      end
    end
  endtask

  task automatic compareAll();
    chkVec(patTag, pattern, buildPat(expSeed, expJohn));
    chkInt("R8 capture", int'(capture), int'(expCap));
    chkInt((mLim == 0) ? "R10 done" : "R9 done", int'(done), int'(mDone));
    if (capture) capSeen++;
    if (sicChk) begin : sic_r6
      bit ok = 1'b1;
      logic [PW-1:0] d = pattern ^ prevPat;
      for (int c = 0; c < M; c++) begin
        int n = 0;
        for (int r = 0; r < L; r++) n += int'(d[r*M + c]);
        if (n != 1) ok = 1'b0;
      end
      chkInt("R6 single change per column", int'(ok), 1);
    end
    prevPat = pattern;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(input bit sc, input int lim, input bit poke);
    int n = 0;
    start = 1'b1; scanSel = sc; patLimit = LW'(lim);
    cycle();
    start = 1'b0;
    capSeen = 0;
    while (!mDone && n < 3000) begin
      start = (poke && n == 10);
      if (start) begin scanSel = ~sc; patLimit = 8'd5; end
      cycle();
      n++;
    end
    start = 1'b0;
    if (!mDone) chkInt("R9 run finished", 0, 1);
    repeat (4) cycle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    rstN = 1'b0; start = 1'b0; scanSel = 1'b0; patLimit = '0;
    mRun = 0; mDone = 0; mScan = 0; mLim = 1; t = 0; expCap = 0; sicChk = 0;
    expSeed = INIT; expJohn = '0; patTag = "R1"; capSeen = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chkVec("R1", pattern, {L{INIT}});
    chkInt("R1 capture", int'(capture), 0);
    chkInt("R1 done", int'(done), 0);
    prevPat = pattern;
    rstN = 1'b1;
    cycle();
    chkVec("R1 after release", pattern, {L{INIT}});

    // R2: one seed period, then row 0 shows the stepped seed
    run(1'b0, 1, 1'b0);
    chkVec("R2 seed step", {{(PW-M){1'b0}}, pattern[M-1:0]}, {{(PW-M){1'b0}}, lfsrNext(INIT)});

    // R5 and R6: several seeds in the per-clock scheme
    run(1'b0, 3, 1'b0);
    chkInt("R8 no capture per-clock", capSeen, 0);

    // R7, R8, R11: scan scheme with a start poke mid-run
    run(1'b1, 2, 1'b1);
    chkInt("R11 capture count", capSeen, 2*2*L);

    // R10: zero seed budget
    run(1'b0, 0, 1'b0);

    // R12: restart after a finished run reloads the seed
    run(1'b0, 2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule